// File: doc/BRIEF.md
# Three-Level Watchdog Transition Monitor

This block supervises a single heartbeat line that can sit at a logic low, a logic high or a floating mid level. An external comparator stage has already resolved the analog level, so the block receives a two-bit state code. The block expects software or firmware to toggle the line between low and high at regular intervals. If the line stays at either logic level for too long, the block drives an active-low fault output. That output remains low until the line toggles again. If the line floats at mid level, supervision is switched off and the output stays released.

Time is measured in strobes on `tick_en`, a single-cycle enable that a prescaler produces. A 32.768 kHz crystal divided by 8 and then by 64 gives a 64 Hz strobe. At that rate the default limit of 96 strobes corresponds to 1.5 s. The limit is a parameter, so the block can be used with other prescaler taps.

Top module: `wdt_tristate_monitor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears its strobe count, releases `wdog_n` to 1 and takes the present state code as its reference level.
- R2: State codes are 2'b00 = low and 2'b01 = high. If the code holds one of these two values and TIMEOUT_TICKS strobes arrive (default 96, which is 1.5 s at 64 Hz), `wdog_n` reads 0 after the clock edge that samples the last strobe. After one strobe fewer, `wdog_n` still reads 1.
- R3: Once `wdog_n` is 0, it stays 0 for as long as the code does not change, no matter how many further strobes arrive.
- R4: A change of the code from low to high, or from high to low, releases `wdog_n` to 1 at the next edge. It also restarts the count, so a further TIMEOUT_TICKS strobes are needed to fault again.
- R5: Code 2'b10 (mid level) disables supervision. `wdog_n` reads 1 after the next edge, even if it was 0, and strobes are ignored while the code stays there.
- R6: Code 2'b11 is reserved and behaves exactly like mid level.
- R7: When the code leaves the disabled states for low or high, counting starts from zero with `wdog_n` at 1. This is not treated as a toggle, and a full TIMEOUT_TICKS strobes are needed before a fault.
- R8: If a low/high toggle and the strobe that would complete the limit arrive in the same cycle, the toggle wins: `wdog_n` stays 1 and the count restarts from zero.
- R9: Clock cycles without a strobe do not advance the count, so no fault occurs without strobes however long the code is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_code | input | 2 | Resolved line state: 00 low, 01 high, 10 mid level, 11 reserved |
| tick_en | input | 1 | Single-cycle time-base strobe from the prescaler |
| wdog_n | output | 1 | Fault output, active low, held until the next toggle |

## Verification
The hardest case to reach is the tie in R8, where a toggle lands in exactly the cycle whose strobe would otherwise complete the limit. The stimulus issues one strobe fewer than the limit while holding the level. It then presents the opposite level and the final strobe together on a single falling edge. After that, it confirms that a full fresh window is needed before the fault appears. Reaching the resume case in R7 is similar: the count is first advanced part-way, then the line is parked in a disabled state with strobes still running, and the remaining window is measured on return.

// File: rtl/wdt3_pkg.sv
// Package: shared state-code type for the three-level watchdog.
// Assumes the comparator stage delivers one of the four codes below.
package wdt3_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_MID  = 2'b10,
        LVL_RSVD = 2'b11
    } lvl_code_e;

endpackage

// File: rtl/wdt_level_decode.sv
// Module: splits the state code into "supervision active" and the logic level.
// Assumes codes 10 and 11 both mean the line is not driven.
module wdt_level_decode
    import wdt3_pkg::*;
(
    input  logic [1:0] code,
    output logic       active,
    output logic       level
);

    lvl_code_e code_e;

    // Purpose: map each code to an active flag and a level bit.
    always_comb begin
        code_e = lvl_code_e'(code);
        unique case (code_e)
            LVL_LOW:  begin active = 1'b1; level = 1'b0; end
            LVL_HIGH: begin active = 1'b1; level = 1'b1; end
            default:  begin active = 1'b0; level = 1'b0; end
        endcase
    end

endmodule

// File: rtl/wdt_ref_tracker.sv
// Module: keeps the previous line state and flags toggles and resumes.
// A toggle is a change between low and high. A resume is a return from
// the disabled states. Reset loads the current input as the reference.
module wdt_ref_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic level,
    output logic kick,
    output logic resume
);

    logic ref_active;
    logic ref_level;

    // Purpose: register the last seen state (also loaded during reset).
    always_ff @(posedge clk) begin
        ref_active <= active;
        if (!rst_n || active) begin
            ref_level <= level;
        end
    end

    // Purpose: compare the present state with the reference.
    always_comb begin
        kick   = active && ref_active && (level != ref_level);
        resume = active && !ref_active;
    end

endmodule

// File: rtl/wdt_tick_timer.sv
// Module: counts strobes since the last restart and latches the fault.
// Assumes restart has priority over a strobe in the same cycle. The count
// saturates at the limit once the fault is latched.
module wdt_tick_timer #(
    parameter int TIMEOUT_TICKS = 96,
    parameter int CW            = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          restart,
    input  logic          tick_en,
    output logic          fault,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    // Purpose: clear, advance or latch the strobe count and the fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (!active || restart) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (tick_en && !fault) begin
            cnt <= cnt + CW'(1);
            if (cnt == LAST) begin
                fault <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_tristate_monitor.sv
// Module: three-level watchdog top. It drives wdog_n low when the line
// holds low or high for TIMEOUT_TICKS strobes, holds it low until the next
// toggle, and stays released while the line floats. The default of
// 96 strobes is 1.5 s at a 64 Hz strobe (32.768 kHz / 8 / 64).
module wdt_tristate_monitor #(
    parameter int TIMEOUT_TICKS = 96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_code,
    input  logic       tick_en,
    output logic       wdog_n
);

    localparam int CW = $clog2(TIMEOUT_TICKS + 1);

    logic          active;
    logic          level;
    logic          kick;
    logic          resume;
    logic          restart;
    logic          fault;
    logic [CW-1:0] tick_cnt;

    wdt_level_decode u_dec (
        .code   (lvl_code),
        .active (active),
        .level  (level)
    );

    wdt_ref_tracker u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .level  (level),
        .kick   (kick),
        .resume (resume)
    );

    // Purpose: a toggle or a resume restarts the window.
    always_comb restart = kick || resume;

    wdt_tick_timer #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .CW            (CW)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .restart (restart),
        .tick_en (tick_en),
        .fault   (fault),
        .cnt     (tick_cnt)
    );

    // Purpose: present the latched fault as an active-low output.
    always_comb wdog_n = !fault;

endmodule

// File: rtl/wdt_tristate_monitor_chk.sv
// Checker: temporal properties of the three-level watchdog, bound to the top.
module wdt_tristate_monitor_chk #(
    parameter int TIMEOUT_TICKS = 96,
    parameter int CW            = $clog2(TIMEOUT_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    lvl_code,
    input logic          tick_en,
    input logic          wdog_n,
    input logic [CW-1:0] cnt
);

    // R1: a reset edge releases the output and clears the count
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (wdog_n && cnt == '0));

    // R2, R9: the output can only fall on an edge that sampled a strobe
    a_r2_fall_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_n) |-> $past(tick_en));

    // R2: the count never passes the limit
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TIMEOUT_TICKS));

    // R3: a held fault persists while the code is unchanged
    a_r3_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_n && $stable(lvl_code)) |=> !wdog_n);

    // R4 and R8: a low/high toggle releases and restarts, even with a strobe
    a_r4_toggle_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_code[1] && !$past(lvl_code[1]) && lvl_code != $past(lvl_code))
        |=> (wdog_n && cnt == '0));

    // R5, R6: a disabled code releases the output and clears the count
    a_r5_disabled_released: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_code[1] |=> (wdog_n && cnt == '0));

    // R7: returning from a disabled code starts a fresh window
    a_r7_resume_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl_code[1]) && !lvl_code[1]) |=> (wdog_n && cnt == '0));

endmodule

bind wdt_tristate_monitor wdt_tristate_monitor_chk #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_code (lvl_code),
    .tick_en  (tick_en),
    .wdog_n   (wdog_n),
    .cnt      (tick_cnt)
);

// File: tb/wdt_tristate_monitor_test.sv
`timescale 1ns/1ps
module wdt_tristate_monitor_test;

    localparam int TO = 96;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] lvl_code;
    logic       tick_en;
    logic       wdog_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    wdt_tristate_monitor #(.TIMEOUT_TICKS(TO)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_code (lvl_code),
        .tick_en  (tick_en),
        .wdog_n   (wdog_n)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Issue n strobes, one cycle high then one cycle low each.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_code(input logic [1:0] c);
        lvl_code = c;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] c);
        rst_n = 1'b0; tick_en = 1'b0; lvl_code = c;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        check(wdog_n, 1'b1, "R1", "released after reset");
        // fault, then reset must clear it and the window
        ticks(TO);
        check(wdog_n, 1'b0, "R1", "fault before re-reset");
        do_reset(2'b00);
        check(wdog_n, 1'b1, "R1", "reset releases fault");
        ticks(TO - 1);
        check(wdog_n, 1'b1, "R1", "count cleared by reset");
    endtask

    task automatic t_timeout(input logic [1:0] c);
        do_reset(c);
        ticks(TO - 1);
        check(wdog_n, 1'b1, "R2", "one strobe short");
        ticks(1);
        check(wdog_n, 1'b0, "R2", "limit reached");
    endtask

    task automatic t_hold_and_toggle();
        do_reset(2'b01);
        ticks(TO);
        ticks(40);
        check(wdog_n, 1'b0, "R3", "fault held under strobes");
        repeat (30) @(negedge clk);
        check(wdog_n, 1'b0, "R3", "fault held idle");
        set_code(2'b00);
        check(wdog_n, 1'b1, "R4", "toggle releases");
        ticks(TO - 1);
        check(wdog_n, 1'b1, "R4", "fresh window after toggle");
        ticks(1);
        check(wdog_n, 1'b0, "R4", "faults after full window");
        set_code(2'b01);
        check(wdog_n, 1'b1, "R4", "low-to-high toggle releases");
    endtask

    task automatic t_disabled(input logic [1:0] c, input string req);
        do_reset(2'b00);
        ticks(TO);
        check(wdog_n, 1'b0, req, "fault before disable");
        set_code(c);
        check(wdog_n, 1'b1, req, "disable releases");
        ticks(2 * TO);
        check(wdog_n, 1'b1, req, "strobes ignored while disabled");
    endtask

    task automatic t_resume();
        do_reset(2'b01);
        ticks(TO / 2);
        set_code(2'b10);
        ticks(TO);
        set_code(2'b01);
        check(wdog_n, 1'b1, "R7", "released on resume");
        ticks(TO - 1);
        check(wdog_n, 1'b1, "R7", "count restarted on resume");
        ticks(1);
        check(wdog_n, 1'b0, "R7", "fault after full window");
        set_code(2'b11);
        set_code(2'b00);
        ticks(TO - 1);
        check(wdog_n, 1'b1, "R7", "resume to other level is fresh");
    endtask

    task automatic t_race();
        do_reset(2'b00);
        ticks(TO - 1);
        lvl_code = 2'b01;
        tick_en  = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
        check(wdog_n, 1'b1, "R8", "toggle beats final strobe");
        ticks(TO - 1);
        check(wdog_n, 1'b1, "R8", "window restarted on tie");
        ticks(1);
        check(wdog_n, 1'b0, "R8", "fault after fresh window");
    endtask

    task automatic t_no_tick();
        do_reset(2'b01);
        ticks(TO - 1);
        repeat (1000) @(negedge clk);
        check(wdog_n, 1'b1, "R9", "no advance without strobes");
        ticks(1);
        check(wdog_n, 1'b0, "R9", "count held across idle cycles");
    endtask

    initial begin
        rst_n = 1'b0; lvl_code = 2'b00; tick_en = 1'b0;
        fork
            begin
                @(negedge clk);
                t_reset();
                t_timeout(2'b00);
                t_timeout(2'b01);
                t_hold_and_toggle();
                t_disabled(2'b10, "R5");
                t_disabled(2'b11, "R6");
                t_resume();
                t_race();
                t_no_tick();
            end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule